// File: doc/BRIEF.md
# Fixed-Frequency Current Chopper Latch

This block is the digital control for one winding phase of a constant-current chopper. A counter divides the system clock down to a fixed PWM period. Each time the period starts, a set/reset latch switches the phase transistor on. The latch stays on until an external current comparator reports that the winding current has reached its reference. The comparator trip input is asynchronous, so the block synchronizes it, and the synchronized trip then switches the transistor off for the rest of the period.

For a short blanking window after each turn-on, the block ignores trips. This stops the turn-on current spike from ending the pulse at once. A trip that is still asserted when the window closes is sampled again and then takes effect. Both phases of a motor use one instance each, with the same clock and the same divider ratio. Their periods therefore start together and cannot beat against each other while the motor holds a position.

A phase-select input from the step sequencer decides whether this phase is driven at all. A global enable turns the gate off immediately. All pins are plain control levels; there is no data stream.

Top module: `chop_phase_latch`

## Requirements
- R1: While rst_n is low, gate_out is 0. After rst_n rises, the period divider starts from zero.
- R2: The period counter runs while enable is high and wraps every DIV_RATIO clocks (default 18). The first period start comes on the DIV_RATIO-th rising edge after reset release or after enable rises. Later period starts come every DIV_RATIO edges.
- R3: On a period-start edge with phase_sel and enable high, the latch sets. gate_out reads 1 directly after that edge.
- R4: trip_in passes through SYNC_STAGES flops (default 2). A trip that rises before edge X, and is not blanked, clears the latch on edge X+SYNC_STAGES.
- R5: For BLANK_CYCLES edges (default 3) after a period-start edge, trips are ignored. A trip still asserted after that window clears the latch on the next edge, which is the edge BLANK_CYCLES+1 after the start.
- R6: If a period start and an effective trip fall on the same edge, the set wins and the latch turns on.
- R7: Once cleared by a trip, the latch stays off until the next period start, even after trip_in falls.
- R8: When enable is low, gate_out is 0 in the same cycle with no clock edge needed. The latch clears and the divider is held at zero.
- R9: When phase_sel is low, a period start does not set the latch. A latch that is already on clears on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_in | input | 1 | Asynchronous current-comparator trip, high when the current reached the reference |
| phase_sel | input | 1 | Sequencer says this phase is to be driven |
| enable | input | 1 | Global enable; low cuts the gate off at once |
| gate_out | output | 1 | Gate drive of the phase switch, 1 = on |

## Verification
The bench raises trips at several offsets inside a period and counts how many cycles the gate stays on. It covers trips early enough that blanking must hold them, trips late enough that only the synchronizer delay counts, and no trip at all. A design that drops the blanking would cut the pulse short. A design that counted the synchronizer wrong would shift every pulse width by a cycle.

A trip held high across a period start checks that the set wins and that the trip takes effect again right after the window; a trip-first priority would keep the gate dark. Dropping enable mid-pulse must kill the gate with no clock edge, and the restart must take a full period. Dropping phase_sel must stop the next set.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    LATCH_HOLD  = 2'd0,
    LATCH_SET   = 2'd1,
    LATCH_CLEAR = 2'd2
  } latch_act_e;

  // Width of a counter that must hold values 0 .. n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

endpackage

// File: rtl/chop_period_div.sv
module chop_period_div
  import chop_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned W = cnt_width(DIV_RATIO);
  localparam logic [W-1:0] LAST = W'(DIV_RATIO - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  // R2: the count wraps to zero after the period start
  a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
  // R8: a stopped divider sits at zero
  a_r8_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0) && !tick);
endmodule

// File: rtl/chop_trip_sync.sv
module chop_trip_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer
  import chop_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  output logic blank
);
  localparam int unsigned BW = cnt_width(BLANK_CYCLES + 1);
  localparam logic [BW-1:0] LOAD = BW'(BLANK_CYCLES);

  logic [BW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (!run)           left_q <= '0;
    else if (start)          left_q <= LOAD;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign blank = (left_q != '0);

  generate
    if (BLANK_CYCLES > 0) begin : g_chk
      // R5: a period start opens the blanking window
      a_r5_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start) |=> blank);
    end
  endgenerate
endmodule

// File: rtl/chop_phase_latch.sv
module chop_phase_latch
  import chop_pkg::*;
#(
  parameter int unsigned DIV_RATIO    = 18,
  parameter int unsigned BLANK_CYCLES = 3,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_in,
  input  logic phase_sel,
  input  logic enable,
  output logic gate_out
);
  logic       period_tick;
  logic       trip_s;
  logic       blank;
  logic       latch_q;
  latch_act_e act;

  chop_period_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .tick  (period_tick)
  );

  chop_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trip_in),
    .sync_out (trip_s)
  );

  chop_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .start (period_tick),
    .blank (blank)
  );

  // Priority: disable/deselect, then period start, then trip.
  always_comb begin
    act = LATCH_HOLD;
    if (!enable || !phase_sel)  act = LATCH_CLEAR;
    else if (period_tick)       act = LATCH_SET;
    else if (trip_s && !blank)  act = LATCH_CLEAR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= 1'b0;
    else begin
      unique case (act)
        LATCH_SET:   latch_q <= 1'b1;
        LATCH_CLEAR: latch_q <= 1'b0;
        default:     latch_q <= latch_q;
      endcase
    end
  end

  assign gate_out = latch_q & enable;

  // R6: a period start always sets, whatever the trip does
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (period_tick && phase_sel && enable) |=> latch_q);
  // R5: nothing but disable/deselect ends a pulse inside blanking
  a_r5_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && blank && phase_sel && enable) |=> latch_q);
  // R7: an off latch only turns on at a period start
  a_r7_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_q && !period_tick) |=> !latch_q);
  // R9: deselected phase is cleared on the next edge
  a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_sel |=> !latch_q);
  // R8: disable clears the latch
  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !latch_q);
endmodule

// File: tb/tb_chop_phase_latch.sv
module tb_chop_phase_latch;
  localparam int DIV = 18;

  logic clk = 1'b0;
  logic rst_n, trip_in, phase_sel, enable;
  logic gate_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  chop_phase_latch dut (
    .clk(clk), .rst_n(rst_n), .trip_in(trip_in),
    .phase_sel(phase_sel), .enable(enable), .gate_out(gate_out)
  );

  // {trip rise before edge X (0 = none), phase_sel, expected on-cycles}
  localparam int VEC [6][3] = '{
    '{1,  1, 4},
    '{2,  1, 4},
    '{5,  1, 7},
    '{10, 1, 12},
    '{0,  1, 18},
    '{5,  0, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at the negedge just after a period-start edge; ends at the next one.
  task automatic run_period(input int rise_k, input int fall_k, input bit next_sel,
                            output int on_cnt);
    on_cnt = 0;
    for (int k = 0; k < DIV; k++) begin
      if (gate_out) on_cnt++;
      if (k == rise_k) trip_in = 1'b1;
      if (k == fall_k) trip_in = 1'b0;
      if (k == DIV - 1) phase_sel = next_sel;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    int zeros;
    rst_n = 1'b0; trip_in = 1'b0; phase_sel = 1'b1; enable = 1'b1;
    repeat (3) @(negedge clk);
    check(gate_out == 1'b0, "R1 gate in reset", gate_out, 0);
    rst_n = 1'b1;

    // R2: first start on the DIV-th edge after release
    zeros = 0;
    for (int i = 0; i < DIV - 1; i++) begin
      @(negedge clk);
      if (!gate_out) zeros++;
    end
    check(zeros == DIV - 1, "R2 no set before first period", zeros, DIV - 1);
    @(negedge clk);
    check(gate_out == 1'b1, "R3 gate on after period start", gate_out, 1);

    // Table walk: R4 sync delay, R5 blanking, R7 stays off, R9 deselect
    for (int v = 0; v < 6; v++) begin
      bit nsel;
      nsel = (v == 5) ? 1'b1 : VEC[v+1][1][0];
      if (v == 0) phase_sel = VEC[0][1][0];
      run_period(VEC[v][0] == 0 ? -1 : VEC[v][0] - 1, 13, nsel, cnt);
      check(cnt == VEC[v][2], $sformatf("R4 R5 R7 R9 vector %0d", v), cnt, VEC[v][2]);
    end

    // R6: trip held through a period start; set wins, trip re-sampled after blanking
    run_period(0, -1, 1'b1, cnt);
    check(cnt == 4, "R5 trip held from start", cnt, 4);
    run_period(-1, -1, 1'b1, cnt);
    check(cnt == 4, "R6 set wins over held trip", cnt, 4);
    run_period(-1, 0, 1'b1, cnt);
    check(cnt == 18, "R5 trip gone by end of window", cnt, 18);

    // R8: enable drop is immediate, restart takes a full period
    repeat (5) @(negedge clk);
    check(gate_out == 1'b1, "R8 gate on before disable", gate_out, 1);
    enable = 1'b0;
    #1;
    check(gate_out == 1'b0, "R8 immediate cut-off", gate_out, 0);
    zeros = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!gate_out) zeros++;
    end
    check(zeros == 10, "R8 held off while disabled", zeros, 10);
    enable = 1'b1;
    zeros = 0;
    for (int i = 0; i < DIV - 1; i++) begin
      @(negedge clk);
      if (!gate_out) zeros++;
    end
    check(zeros == DIV - 1, "R8 R2 restart from zero", zeros, DIV - 1);
    @(negedge clk);
    check(gate_out == 1'b1, "R2 first set after enable", gate_out, 1);

    // R9: deselect mid-pulse, then no set at the next start
    repeat (3) @(negedge clk);
    phase_sel = 1'b0;
    #1;
    check(gate_out == 1'b1, "R9 latch still on before edge", gate_out, 1);
    @(negedge clk);
    check(gate_out == 1'b0, "R9 cleared on next edge", gate_out, 0);
    cnt = 0;
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge clk);
      if (gate_out) cnt++;
    end
    check(cnt == 0, "R9 no set while deselected", cnt, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule